// File: doc/BRIEF.md
# System Control Register Bank

This block holds the processor's privileged system control registers and serves the move-to and move-from requests a core issues toward its control coprocessor. Each request gives a primary index (`req_crn`, 0 to 15), a secondary index (`req_crm`), two opcode fields (`req_op1`, `req_op2`) and a flag that marks privileged mode. The bank decides whether the index and opcode combination is legal. Only a legal write changes storage, and each register applies its own write mask and forced-one bits on the way in. A legal read returns the stored value.

The bank has one response path. A request presented on a rising edge gets its answer on the outputs in the following cycle: `resp_valid` is high, `resp_accept` gives the legality, and `resp_rdata` carries the read data. A second register set, selected when `req_op2` is nonzero, sits behind indices 0 and 1. Five debug registers sit behind index 14 and are picked by `req_crm`. Registers 7, 8 and 10 stand for cache and translation maintenance operations. Their legality is checked, but writes to them do nothing and they read as zero.

The control register drives two levels. `endian_big` is bit 7 and `align_check_en` is bit 1. When a write flips bit 7, `mode_change` pulses for one cycle alongside the response. The block has no state machine: every accepted request finishes in one cycle and no request is ever held.

Top module: `sysctl_bank`

## Requirements
- R1: A request with `req_priv`=0 is rejected, and so is any request with `req_op1`≠0, whatever the other fields hold.
- R2: Indices 4, 11 and 12 always reject. Indices 2, 3, 5, 6 and 13 accept only with crm=0 and op2=0. Indices 0 and 1 accept crm=0 with any op2. Index 9 accepts crm 0 or 1 with op2 1 or 2. Index 10 accepts crm 0 or 1 with op2=4. Index 15 accepts only crm=1 with op2=0.
- R3: Index 7 accepts only these (op2, crm) pairs: (0,5), (0,6), (0,7), (1,5), (1,6), (1,10), (4,10), (5,2) and (6,5). Index 8 accepts op2 0 or 1 with crm 5 to 7, except the pair (1,7).
- R4: Index 14 accepts op2=0 with crm 0, 3, 4, 8 or 9. Each of these crm values selects its own fully writable 32-bit register, and each resets to 0.
- R5: After reset, index 0 with op2=0 reads 0x69052000, index 0 with op2≠0 reads 0x0B1AA1AA, and index 1 with op2=0 reads 0x00000078. Every other legal read returns 0.
- R6: A write to index 1 with op2=0 stores (data AND 0x00003B87) OR 0x00000078.
- R7: Writes to index 0 are discarded for every op2. A write to index 1 with op2≠0 stores data AND 0x33 into the second set, and that value is read back for every op2≠0 and leaves the op2=0 register untouched.
- R8: Write masks: index 2 uses 0xFFFFC000, index 5 uses 0x000006FF, index 9 uses 0x1 (one register shared by all its legal op2 values), index 13 uses 0xFE000000 and index 15 uses 0x00003FFF. Indices 3 and 6 store all 32 bits.
- R9: Writes to indices 7, 8 and 10 change nothing, and legal reads of them return 0.
- R10: `endian_big` equals control bit 7 and `align_check_en` equals control bit 1. `mode_change` is high for exactly the response cycle of an accepted control write that changes bit 7.
- R11: A request seen at a rising edge gives `resp_valid`=1 in the next cycle, and no request gives `resp_valid`=0. A rejected request changes no register and returns `resp_rdata`=0. A write response also carries `resp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to the bank, 0 = move from the bank |
| req_priv | input | 1 | Requester is in a privileged mode |
| req_crn | input | 4 | Primary register index |
| req_crm | input | 4 | Secondary register index |
| req_op1 | input | 3 | First opcode field, must be zero |
| req_op2 | input | 3 | Second opcode field, selects the second set |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present |
| resp_accept | output | 1 | Request was legal and performed |
| resp_rdata | output | 32 | Read data, 0 on rejects and writes |
| mode_change | output | 1 | One-cycle pulse when the endianness bit flips |
| endian_big | output | 1 | Current endianness level (control bit 7) |
| align_check_en | output | 1 | Alignment-check enable (control bit 1) |

## Verification
A wrong legality decoding shows up as a flipped `resp_accept` on the very next cycle. A wrong mask, a wrong forced bit or a write that leaks into another register stays hidden until that register is read. For that reason every write in the sweep is followed at once by a read of the same index, so a bad stored value surfaces at most two cycles after the write that caused it. A lost or spurious endianness flip is seen in the response cycle itself, both through `mode_change` and through `endian_big` disagreeing with the model.

// File: rtl/scrb_pkg.sv
package scrb_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned IDX_W   = 4;
    localparam int unsigned OP_W    = 3;
    localparam int unsigned NUM_IDX = 1 << IDX_W;
    localparam int unsigned NUM_DBG = 5;

    localparam logic [DATA_W-1:0] ID_VALUE    = 32'h6905_2000;
    localparam logic [DATA_W-1:0] ALT0_VALUE  = 32'h0B1A_A1AA;
    localparam logic [DATA_W-1:0] CTRL_RESET  = 32'h0000_0078;
    localparam logic [DATA_W-1:0] CTRL_FORCE  = 32'h0000_0078;
    localparam logic [DATA_W-1:0] ALT1_MASK   = 32'h0000_0033;
    localparam int unsigned       ENDIAN_BIT  = 7;
    localparam int unsigned       ALIGN_BIT   = 1;

    typedef struct packed {
        logic [IDX_W-1:0] crn;
        logic [IDX_W-1:0] crm;
        logic [OP_W-1:0]  op1;
        logic [OP_W-1:0]  op2;
        logic             priv;
    } sc_req_t;

    // write mask of the op2 == 0 register behind each primary index;
    // zero means nothing is stored there
    function automatic logic [DATA_W-1:0] prim_wmask(input int idx);
        case (idx)
            1:       return 32'h0000_3B87;
            2:       return 32'hFFFF_C000;
            3:       return 32'hFFFF_FFFF;
            5:       return 32'h0000_06FF;
            6:       return 32'hFFFF_FFFF;
            9:       return 32'h0000_0001;
            13:      return 32'hFE00_0000;
            15:      return 32'h0000_3FFF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] prim_force(input int idx);
        return (idx == 1) ? CTRL_FORCE : '0;
    endfunction

    function automatic logic [DATA_W-1:0] prim_reset(input int idx);
        return (idx == 1) ? CTRL_RESET : '0;
    endfunction

    // crm code that selects each debug slot behind index 14
    function automatic logic [IDX_W-1:0] dbg_crm(input int slot);
        case (slot)
            0:       return 4'd0;
            1:       return 4'd3;
            2:       return 4'd4;
            3:       return 4'd8;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/scrb_access_check.sv
module scrb_access_check
    import scrb_pkg::*;
(
    input  sc_req_t req_i,
    output logic    legal_o
);

    logic idx_ok;
    logic crm_zero;
    logic op2_zero;

    assign crm_zero = (req_i.crm == '0);
    assign op2_zero = (req_i.op2 == '0);

    always_comb begin
        idx_ok = 1'b0;
        unique case (req_i.crn)
            4'd0, 4'd1:
                idx_ok = crm_zero;
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
                idx_ok = crm_zero && op2_zero;
            4'd7: begin
                unique case (req_i.op2)
                    3'd0:    idx_ok = (req_i.crm >= 4'd5) && (req_i.crm <= 4'd7);
                    3'd1:    idx_ok = (req_i.crm == 4'd5) || (req_i.crm == 4'd6) ||
                                      (req_i.crm == 4'd10);
                    3'd4:    idx_ok = (req_i.crm == 4'd10);
                    3'd5:    idx_ok = (req_i.crm == 4'd2);
                    3'd6:    idx_ok = (req_i.crm == 4'd5);
                    default: idx_ok = 1'b0;
                endcase
            end
            4'd8:
                idx_ok = (req_i.op2 <= 3'd1) && (req_i.crm >= 4'd5) &&
                         (req_i.crm <= 4'd7) &&
                         !((req_i.op2 == 3'd1) && (req_i.crm == 4'd7));
            4'd9:
                idx_ok = (req_i.crm <= 4'd1) &&
                         ((req_i.op2 == 3'd1) || (req_i.op2 == 3'd2));
            4'd10:
                idx_ok = (req_i.crm <= 4'd1) && (req_i.op2 == 3'd4);
            4'd14:
                idx_ok = op2_zero &&
                         ((req_i.crm == 4'd0) || (req_i.crm == 4'd3) ||
                          (req_i.crm == 4'd4) || (req_i.crm == 4'd8) ||
                          (req_i.crm == 4'd9));
            4'd15:
                idx_ok = (req_i.crm == 4'd1) && op2_zero;
            default:
                idx_ok = 1'b0;
        endcase
    end

    assign legal_o = req_i.priv && (req_i.op1 == '0) && idx_ok;

endmodule

// File: rtl/scrb_regfile.sv
module scrb_regfile
    import scrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  crn,
    input  logic [IDX_W-1:0]  crm,
    input  logic [OP_W-1:0]   op2,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              endian_flip
);

    logic [DATA_W-1:0] prim_q [NUM_IDX];
    logic [DATA_W-1:0] dbg_q  [NUM_DBG];
    logic [DATA_W-1:0] alt1_q;
    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_next;

    // primary registers: storage only where a mask exists
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_prim
        if (prim_wmask(g) != '0) begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= prim_reset(g);
                else if (wr_en && (crn == IDX_W'(g)) && ((g != 1) || (op2 == '0)))
                    q <= (wdata & prim_wmask(g)) | prim_force(g);
            end
            assign prim_q[g] = q;
        end else begin : g_none
            assign prim_q[g] = '0;
        end
    end

    // debug registers behind index 14, one per crm code
    for (genvar s = 0; s < NUM_DBG; s++) begin : g_dbg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (crn == 4'd14) && (crm == dbg_crm(s)))
                q <= wdata;
        end
        assign dbg_q[s] = q;
    end

    // second set: only index 1 is writable
    always_ff @(posedge clk) begin
        if (!rst_n)
            alt1_q <= '0;
        else if (wr_en && (crn == 4'd1) && (op2 != '0))
            alt1_q <= wdata & ALT1_MASK;
    end

    assign ctrl_q      = prim_q[1];
    assign ctrl_wr     = wr_en && (crn == 4'd1) && (op2 == '0);
    assign ctrl_next   = (wdata & prim_wmask(1)) | prim_force(1);
    assign endian_flip = ctrl_wr && (ctrl_next[ENDIAN_BIT] != ctrl_q[ENDIAN_BIT]);

    always_comb begin
        rdata = '0;
        case (crn)
            4'd0:    rdata = (op2 != '0) ? ALT0_VALUE : ID_VALUE;
            4'd1:    rdata = (op2 != '0) ? alt1_q : ctrl_q;
            4'd7, 4'd8, 4'd10:
                     rdata = '0;
            4'd14: begin
                case (crm)
                    4'd0:    rdata = dbg_q[0];
                    4'd3:    rdata = dbg_q[1];
                    4'd4:    rdata = dbg_q[2];
                    4'd8:    rdata = dbg_q[3];
                    4'd9:    rdata = dbg_q[4];
                    default: rdata = '0;
                endcase
            end
            default: rdata = prim_q[crn];
        endcase
    end

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (crn == 4'd1) && (op2 == '0)) |=> $stable(ctrl_q));

    // R7
    alt_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (crn == 4'd1) && (op2 != '0)) |=> $stable(alt1_q));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import scrb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_priv,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op1,
    input  logic [2:0]  req_op2,
    input  logic [31:0] req_wdata,
    output logic        resp_valid,
    output logic        resp_accept,
    output logic [31:0] resp_rdata,
    output logic        mode_change,
    output logic        endian_big,
    output logic        align_check_en
);

    sc_req_t           req;
    logic              legal;
    logic              wr_en;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] ctrl;
    logic              flip;

    assign req = '{crn: req_crn, crm: req_crm, op1: req_op1, op2: req_op2, priv: req_priv};

    scrb_access_check u_check (
        .req_i   (req),
        .legal_o (legal)
    );

    assign wr_en = req_valid && req_write && legal;

    scrb_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .crn         (req_crn),
        .crm         (req_crm),
        .op2         (req_op2),
        .wdata       (req_wdata),
        .rdata       (rd_val),
        .ctrl_q      (ctrl),
        .endian_flip (flip)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
            resp_rdata  <= '0;
            mode_change <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            resp_accept <= req_valid && legal;
            resp_rdata  <= (req_valid && legal && !req_write) ? rd_val : '0;
            mode_change <= flip;
        end
    end

    assign endian_big     = ctrl[ENDIAN_BIT];
    assign align_check_en = ctrl[ALIGN_BIT];

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    // R1
    user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv) |=> !resp_accept);

    // R11
    reject_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_accept) |-> (resp_rdata == '0));

    // R10
    flip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> (resp_accept && (endian_big != $past(endian_big))));

endmodule

// File: tb/sysctl_bank_test.sv
`timescale 1ns/1ps
module sysctl_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op1 = '0;
    logic [2:0]  req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_accept, mode_change, endian_big, align_check_en;
    logic [31:0] resp_rdata;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1357_9BDF;

    // bench model of the storage
    logic [31:0] m_reg [16];
    logic [31:0] m_alt1;
    logic [31:0] m_dbg [16];

    always #2.5 clk = ~clk;

    sysctl_bank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_crn(req_crn), .req_crm(req_crm),
        .req_op1(req_op1), .req_op2(req_op2), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_accept(resp_accept), .resp_rdata(resp_rdata),
        .mode_change(mode_change), .endian_big(endian_big),
        .align_check_en(align_check_en)
    );

    function automatic bit exp_legal(input bit pv, input logic [2:0] o1,
                                     input logic [3:0] n, input logic [3:0] m,
                                     input logic [2:0] o2);
        logic [6:0] key;
        key = {o2, m};
        if (!pv || o1 != 0) return 0;                       // R1
        case (n)
            0, 1:  return m == 0;                            // R2
            2, 3, 5, 6, 13: return m == 0 && o2 == 0;        // R2
            7:     return key == {3'd0,4'd5} || key == {3'd0,4'd6} ||
                          key == {3'd0,4'd7} || key == {3'd1,4'd5} ||
                          key == {3'd1,4'd6} || key == {3'd1,4'd10} ||
                          key == {3'd4,4'd10} || key == {3'd5,4'd2} ||
                          key == {3'd6,4'd5};                // R3
            8:     return (o2 == 0 && m >= 5 && m <= 7) ||
                          (o2 == 1 && (m == 5 || m == 6));   // R3
            9:     return m <= 1 && (o2 == 1 || o2 == 2);
            10:    return m <= 1 && o2 == 4;
            14:    return o2 == 0 && (m == 0 || m == 3 || m == 4 || m == 8 || m == 9); // R4
            15:    return m == 1 && o2 == 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] n, input logic [3:0] m,
                                             input logic [2:0] o2);
        case (n)
            0:  return (o2 != 0) ? 32'h0B1AA1AA : 32'h69052000;
            1:  return (o2 != 0) ? m_alt1 : m_reg[1];
            7, 8, 10: return 32'h0;
            14: return m_dbg[m];
            default: return m_reg[n];
        endcase
    endfunction

    function automatic logic [31:0] masked(input logic [3:0] n, input logic [31:0] d);
        case (n)
            1:  return (d & 32'h3B87) | 32'h78;
            2:  return d & 32'hFFFFC000;
            5:  return d & 32'h6FF;
            9:  return d & 32'h1;
            13: return d & 32'hFE000000;
            15: return d & 32'h3FFF;
            default: return d;
        endcase
    endfunction

    function automatic string data_tag(input logic [3:0] n, input logic [2:0] o2);
        if (n == 0 || (n == 1 && o2 != 0)) return "R7";
        if (n == 1) return "R6";
        if (n == 7 || n == 8 || n == 10) return "R9";
        if (n == 14) return "R4";
        return "R8";
    endfunction

    function automatic string legal_tag(input bit pv, input logic [2:0] o1, input logic [3:0] n);
        if (!pv || o1 != 0) return "R1";
        if (n == 7 || n == 8) return "R3";
        if (n == 14) return "R4";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_reg[i] = '0;
            m_dbg[i] = '0;
        end
        m_reg[1] = 32'h78;
        m_alt1 = '0;
    endtask

    // one request: drive after a falling edge, check at the next falling edge
    task automatic op(input bit w, input bit pv, input logic [2:0] o1,
                      input logic [3:0] n, input logic [3:0] m, input logic [2:0] o2,
                      input logic [31:0] d, input string dtag, output bit acc);
        bit el, emc;
        logic [31:0] er;
        el  = exp_legal(pv, o1, n, m, o2);
        er  = (!w && el) ? exp_read(n, m, o2) : 32'h0;
        emc = w && el && n == 1 && o2 == 0 && (masked(1, d)[7] != m_reg[1][7]);
        req_valid = 1'b1; req_write = w; req_priv = pv; req_op1 = o1;
        req_crn = n; req_crm = m; req_op2 = o2; req_wdata = d;
        @(negedge clk);
        chk(resp_valid == 1'b1, "R11", "resp_valid", 32'(resp_valid), 32'h1);
        chk(resp_accept == el, legal_tag(pv, o1, n), "accept",
            32'(resp_accept), 32'(el));
        chk(resp_rdata == er, el ? dtag : "R11", "rdata", resp_rdata, er);
        chk(mode_change == emc, "R10", "mode_change", 32'(mode_change), 32'(emc));
        if (w && el) begin
            if (n == 1 && o2 != 0) m_alt1 = d & 32'h33;
            else if (n == 14) m_dbg[m] = d;
            else if (n != 0 && n != 7 && n != 8 && n != 10) m_reg[n] = masked(n, d);
        end
        chk({endian_big, align_check_en} == {m_reg[1][7], m_reg[1][1]}, "R10",
            "endian/align", {30'h0, endian_big, align_check_en},
            {30'h0, m_reg[1][7], m_reg[1][1]});
        acc = resp_accept;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        bit acc;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5 reset state at the ports
        chk(resp_valid == 0 && mode_change == 0, "R5", "idle outputs",
            {30'h0, resp_valid, mode_change}, 32'h0);
        chk(endian_big == 0 && align_check_en == 0, "R5", "control levels",
            {30'h0, endian_big, align_check_en}, 32'h0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(resp_valid == 0, "R11", "no request no response", 32'(resp_valid), 32'h0);

        // Phase A: exhaustive read sweep from reset state (R1..R5, R9)
        for (int pv = 0; pv < 2; pv++)
            for (int o1 = 0; o1 < 2; o1++)
                for (int n = 0; n < 16; n++)
                    for (int m = 0; m < 16; m++)
                        for (int o2 = 0; o2 < 8; o2++)
                            op(1'b0, pv[0], 3'(o1 * 3), 4'(n), 4'(m), 3'(o2), 32'h0,
                               "R5", acc);

        // Phase B: exhaustive write sweep, each write read back (R6..R11)
        for (int pv = 0; pv < 2; pv++)
            for (int o1 = 0; o1 < 2; o1++)
                for (int n = 0; n < 16; n++)
                    for (int m = 0; m < 16; m++)
                        for (int o2 = 0; o2 < 8; o2++) begin
                            seed = seed ^ (seed << 13);
                            seed = seed ^ (seed >> 17);
                            seed = seed ^ (seed << 5);
                            op(1'b1, pv[0], 3'(o1 * 5), 4'(n), 4'(m), 3'(o2), seed,
                               data_tag(4'(n), 3'(o2)), acc);
                            // a rejected write must leave the read value as before (R11)
                            op(1'b0, 1'b1, 3'd0, 4'(n), 4'(m), 3'(o2), 32'h0,
                               acc ? data_tag(4'(n), 3'(o2)) : "R11", acc);
                        end

        // Directed control register cases (R6, R10)
        op(1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, "R6", acc);
        op(1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'hFFFF_FFFF, "R6", acc);
        op(1'b0, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, "R6", acc);
        chk(resp_rdata == 32'h3BFF, "R6", "all-ones control", resp_rdata, 32'h3BFF);
        op(1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h80, "R10", acc);
        op(1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, "R10", acc);
        chk(endian_big == 1'b1, "R1", "user write ignored", 32'(endian_big), 32'h1);
        op(1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, "R10", acc);

        req_valid = 1'b0;
        @(negedge clk);
        chk(resp_valid == 0 && mode_change == 0, "R11", "idle after traffic",
            {30'h0, resp_valid, mode_change}, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule